// File: doc/BRIEF.md
# Alternating-Polarity Edge Timestamp Recorder

This block records when each transition on one asynchronous serial line arrives, so that software or a later stage can reconstruct the pulse widths from the stored times. A free-running counter on the system clock supplies the time base, with no prescaler. At every accepted edge, the low byte of that counter is written into an on-chip buffer. Decoding the stream into data bits is left to whatever reads the buffer.

A one-cycle `arm_i` pulse starts a capture. The block first waits until the synchronised line is low, then for the rising edge of the leading mark, and stores that edge as the first timestamp. From then on it watches for only one polarity at a time: a falling edge after a rising one, and a rising edge after a falling one. Capture ends in one of two ways. Either the buffer fills, or no edge arrives within a programmable number of clocks. When capture ends, `done_o` rises and `edge_cnt_o` holds the number of valid timestamps.

A registered read port gives access to the buffer at any time. Slots at or beyond the reported count hold no defined value.

Top module: `edge_stamp_capture`

## Requirements
- R1: After reset, `done_o` is 0 and `edge_cnt_o` is 0.
- R2: The line passes through a two-flop synchroniser. An edge is found by comparing two successive synchronised samples. Every line level held for at least 3 clocks produces exactly one stored timestamp.
- R3: The n-th accepted edge, counting from 0, is written to buffer slot n. The value written is the low 8 bits of a counter that advances once per clock. The difference between consecutive slots, modulo 256, therefore equals the time between the two edges in clocks.
- R4: After `arm_i`, nothing is recorded until the synchronised line has been seen low. A high level already present at arming is not recorded, and neither is its falling edge.
- R5: Slot 0 holds the rising edge of the start mark. After that, the stored edges alternate in polarity: even slots hold rising edges and odd slots hold falling edges.
- R6: Capture stops once 2*PAIRS (default 128) timestamps are stored. At that point `done_o` is 1 and `edge_cnt_o` equals 2*PAIRS, and later edges are not recorded.
- R7: During capture, if no edge is accepted for `timeout_i` clocks, `done_o` rises. `edge_cnt_o` then holds the number of stored timestamps. Every accepted edge restarts this timer.
- R8: Once `done_o` is 1, it stays 1, and `edge_cnt_o` and the buffer stay unchanged, until the next `arm_i`. A new `arm_i` clears `done_o` and `edge_cnt_o` on the following clock.
- R9: `rd_data_o` shows the content of slot `rd_addr_i` one clock after the address is applied.
- R10: A pulse longer than 255 clocks is stored with its width wrapped modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timestamp time base |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | One-cycle pulse that starts a new capture |
| line_i | input | 1 | Asynchronous serial line being observed |
| timeout_i | input | 16 | Inactivity limit in clocks |
| done_o | output | 1 | Capture has ended |
| edge_cnt_o | output | 8 | Number of valid timestamps stored |
| rd_addr_i | input | 7 | Buffer read address |
| rd_data_o | output | 8 | Buffer read data, one clock after the address |

## Verification
The hardest case to reach from the ports is arming while the line already sits high in the middle of a pulse. If the block captured there, it would take the wrong level as the start mark and shift the polarity of every later slot. The stimulus raises the line before the arm pulse, keeps it high, drops it, and only then sends the real mark. The bench then checks the count and the width sequence against the mark alone. Running the buffer full with a long train of short pulses is the other case that needs deliberate effort; it exercises the end of the buffer and the point at which recording stops.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [2:0] {
    CS_IDLE,
    CS_SEEK_LOW,
    CS_SEEK_MARK,
    CS_RECORD,
    CS_FINISHED
  } cap_state_t;

  // polarity the recorder is currently waiting for
  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } pol_t;

  function automatic pol_t pol_flip(input pol_t p);
    return (p == POL_RISE) ? POL_FALL : POL_RISE;
  endfunction
endpackage

// File: rtl/esc_sync_edge.sv
module esc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;
  logic              rise_q, fall_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= 1'b0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  // compare successive synchronised samples
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= stage_q[STAGES-1];
      rise_q <= stage_q[STAGES-1] & ~prev_q;
      fall_q <= ~stage_q[STAGES-1] & prev_q;
    end
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;

  // R2: one sample pair cannot be both a rise and a fall
  p_single_kind_r2: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o));
endmodule

// File: rtl/esc_stamp_ram.sv
module esc_stamp_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  // simple dual port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/esc_ctrl.sv
module esc_ctrl
  import esc_pkg::*;
#(
  parameter int STAMP_W = 8,
  parameter int DEPTH   = 128,
  parameter int TO_W    = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm_i,
  input  logic               level_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic [TO_W-1:0]    timeout_i,
  output logic               we_o,
  output logic [AW-1:0]      waddr_o,
  output logic [STAMP_W-1:0] wdata_o,
  output logic               done_o,
  output logic [CW-1:0]      cnt_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  cap_state_t         state_q;
  pol_t               want_q;
  logic [STAMP_W-1:0] stamp_q;
  logic [CW-1:0]      cnt_q;
  logic [TO_W-1:0]    idle_q;
  logic               done_q;
  logic               hit;
  logic [TO_W:0]      idle_next;

  // free-running time base, no prescaler
  always_ff @(posedge clk) begin
    if (rst) stamp_q <= '0;
    else     stamp_q <= stamp_q + 1'b1;
  end

  always_comb begin
    hit = 1'b0;
    unique case (state_q)
      CS_SEEK_MARK: hit = rise_i;
      CS_RECORD:    hit = (want_q == POL_FALL) ? fall_i : rise_i;
      default:      hit = 1'b0;
    endcase
  end

  assign idle_next = {1'b0, idle_q} + 1'b1;
  assign we_o      = hit & ~arm_i;
  assign waddr_o   = cnt_q[AW-1:0];
  assign wdata_o   = stamp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CS_IDLE;
      want_q  <= POL_RISE;
      cnt_q   <= '0;
      idle_q  <= '0;
      done_q  <= 1'b0;
    end else if (arm_i) begin
      state_q <= CS_SEEK_LOW;
      want_q  <= POL_RISE;
      cnt_q   <= '0;
      idle_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        CS_IDLE: ;
        CS_SEEK_LOW: begin
          if (!level_i) state_q <= CS_SEEK_MARK;
        end
        CS_SEEK_MARK: begin
          if (hit) begin
            state_q <= CS_RECORD;
            want_q  <= POL_FALL;
            cnt_q   <= cnt_q + 1'b1;
            idle_q  <= '0;
          end
        end
        CS_RECORD: begin
          if (hit) begin
            cnt_q  <= cnt_q + 1'b1;
            want_q <= pol_flip(want_q);
            idle_q <= '0;
            if (cnt_q + 1'b1 == FULL) begin
              state_q <= CS_FINISHED;
              done_q  <= 1'b1;
            end
          end else begin
            idle_q <= idle_next[TO_W-1:0];
            if (idle_next >= {1'b0, timeout_i}) begin
              state_q <= CS_FINISHED;
              done_q  <= 1'b1;
            end
          end
        end
        CS_FINISHED: ;
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign cnt_o  = cnt_q;

  // R6: count never exceeds the buffer size
  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  // R6: a full buffer means capture has finished
  p_full_is_done_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL) |-> done_q);
  // R8: finished results stay frozen until re-armed
  p_done_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (done_q && !arm_i) |=> (done_q && $stable(cnt_q)));
  // R3: each buffer write advances the count by one
  p_write_advances_r3: assert property (@(posedge clk) disable iff (rst)
    we_o |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R8: no buffer write after capture has finished
  p_no_write_done_r8: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !we_o);
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture #(
  parameter int PAIRS   = 64,
  parameter int STAMP_W = 8,
  parameter int TO_W    = 16,
  parameter int SYNC    = 2,
  localparam int DEPTH  = 2 * PAIRS,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm_i,
  input  logic               line_i,
  input  logic [TO_W-1:0]    timeout_i,
  output logic               done_o,
  output logic [CW-1:0]      edge_cnt_o,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [STAMP_W-1:0] rd_data_o
);
  logic               level, rise, fall;
  logic               we;
  logic [AW-1:0]      waddr;
  logic [STAMP_W-1:0] wdata;

  esc_sync_edge #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .line_i(line_i),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  esc_ctrl #(.STAMP_W(STAMP_W), .DEPTH(DEPTH), .TO_W(TO_W)) u_ctrl (
    .clk(clk), .rst(rst), .arm_i(arm_i),
    .level_i(level), .rise_i(rise), .fall_i(fall),
    .timeout_i(timeout_i),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .done_o(done_o), .cnt_o(edge_cnt_o)
  );

  esc_stamp_ram #(.DW(STAMP_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );
endmodule

// File: tb/edge_stamp_capture_bench.sv
module edge_stamp_capture_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic        line = 1'b0;
  logic [15:0] tmo = 16'd60;
  logic        done;
  logic [7:0]  cnt;
  logic [6:0]  raddr = '0;
  logic [7:0]  rdata;

  int applied = 0;
  int errors  = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  edge_stamp_capture u_edge_stamp_capture (
    .clk(clk), .rst(rst), .arm_i(arm), .line_i(line), .timeout_i(tmo),
    .done_o(done), .edge_cnt_o(cnt), .rd_addr_i(raddr), .rd_data_o(rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    arm = 1'b1;
    hold(1);
    arm = 1'b0;
  endtask

  // driver: start mark rise, then toggle after each width; queue expected widths
  task automatic send(input int w[]);
    line = 1'b1;
    foreach (w[i]) begin
      hold(w[i]);
      line = ~line;
      exp_q.push_back(w[i] % 256);
    end
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !done; i++) hold(1);
  endtask

  function automatic logic [7:0] dummy_read(input int a);
    return 8'(a);
  endfunction

  task automatic read_slot(input int a, output int v);
    raddr = a[6:0];
    hold(1);
    v = int'(rdata);
  endtask

  // monitor: pop expected widths and compare with stamp differences
  task automatic score(input string req, input int n_valid);
    int prev, cur;
    read_slot(0, prev);
    for (int i = 1; i < n_valid; i++) begin
      read_slot(i, cur);
      if (exp_q.size() > 0) chk(req, (cur - prev) & 255, exp_q.pop_front());
      prev = cur;
    end
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin : main
    int v0, v1;
    hold(3);
    rst = 1'b0;
    hold(1);
    // R1 reset state
    chk("R1 done", int'(done), 0);
    chk("R1 count", int'(cnt), 0);

    // R3 R5 R7 R9: mixed widths, timeout ends capture
    tmo = 16'd60;
    do_arm();
    hold(5);
    send('{10, 12, 10, 30, 11, 14, 20});
    hold(54);
    chk("R7 no early done", int'(done), 0);
    hold(14);
    chk("R7 done after idle", int'(done), 1);
    chk("R7 count", int'(cnt), 8);
    score("R3 R5 R9 widths", 8);

    // R8: frozen after done, re-arm clears
    read_slot(3, v0);
    line = 1'b1; hold(8); line = 1'b0; hold(8);
    chk("R8 count frozen", int'(cnt), 8);
    read_slot(3, v1);
    chk("R8 buffer frozen", v1, v0);
    do_arm();
    chk("R8 rearm done", int'(done), 0);
    chk("R8 rearm count", int'(cnt), 0);

    // R4: armed while line high, that pulse ignored
    hold(4);
    line = 1'b1;
    hold(5);
    do_arm();
    hold(20);
    line = 1'b0;
    hold(15);
    send('{9, 17, 25});
    wait_done();
    chk("R4 count", int'(cnt), 4);
    score("R4 widths", 4);

    // R10: wrap beyond 255 clocks, R7 timer restarted by edges
    tmo = 16'd400;
    do_arm();
    hold(5);
    send('{300, 20, 7});
    wait_done();
    chk("R10 count", int'(cnt), 4);
    score("R10 wrapped widths", 4);

    // R2: short 3-clock levels
    tmo = 16'd60;
    do_arm();
    hold(5);
    send('{3, 3, 4, 3, 5});
    wait_done();
    chk("R2 count", int'(cnt), 6);
    score("R2 short widths", 6);

    // R6: buffer fills, later edges dropped
    do_arm();
    hold(5);
    begin
      int w[];
      w = new[141];
      foreach (w[i]) w[i] = 5 + (i % 7);
      send(w);
    end
    wait_done();
    chk("R6 done", int'(done), 1);
    chk("R6 count full", int'(cnt), 128);
    score("R6 widths", 128);

    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule